// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps a small number of recent page mappings so that a virtual page number can be turned into a physical page number without going out to the in-memory page table. An 8-bit virtual page number is presented together with a 6-bit page offset and an access kind (read or write). The low bits of the page number pick one of four sets. The remaining bits are compared, all at once, against the four ways of that set. On a match the cached physical page number and the offset are joined into a 12-bit physical address in the same cycle.

When no way matches, the miss output tells the surrounding logic to walk the page table. The walker then writes the mapping back through the refill port. Each cached mapping also carries read and write permission bits, so a hit can flag an access that is not allowed without any walk. A flush input empties the whole structure in one cycle, for use when the active address space changes.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until a refill has been made.
- R2: The set is chosen by page-number bits [1:0] and the tag is bits [7:2]. A hit needs a valid way in the chosen set whose stored tag equals the tag, and the result is combinational in the same cycle as the lookup inputs.
- R3: On a hit, `lk_ppn` is the stored 6-bit physical page and `lk_paddr` equals {`lk_ppn`, `lk_ofs`}, with the offset unchanged. On a miss both are zero.
- R4: `lk_miss` is high exactly when `lk_valid` is high and no way matches. With `lk_valid` low, both `lk_hit` and `lk_miss` are low.
- R5: A refill presented with `fill_en` at a clock edge is visible to lookups from the next cycle on, and not before that edge.
- R6: A refill of a page that is not yet cached writes the lowest-numbered invalid way of its set, when one exists, and leaves the replacement pointer of that set alone.
- R7: When all four ways of the set are valid, the refill replaces the way named by that set's round-robin pointer (0 after reset), and the pointer then steps by one, wrapping from 3 to 0. Each set has its own pointer, and flushing does not change it.
- R8: A refill whose page already matches a valid way overwrites that way in place, so a page never occupies two ways, and the replacement pointer does not move.
- R9: `flush` makes every entry invalid at the next clock edge. A refill in the same cycle as a flush is dropped.
- R10: On a hit, `lk_fault` is high when a read (`lk_write`=0) finds the read permission clear, or when a write (`lk_write`=1) finds the write permission clear. `lk_hit` and `lk_ppn` are still reported. `lk_fault` is never high without a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup is being presented |
| lk_vpn | input | 8 | Virtual page number to translate |
| lk_ofs | input | 6 | Page offset, passed through unchanged |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| lk_hit | output | 1 | Matching valid way found |
| lk_miss | output | 1 | No match; a page-table walk is needed |
| lk_ppn | output | 6 | Physical page number on a hit |
| lk_paddr | output | 12 | Physical address on a hit |
| lk_fault | output | 1 | Hit whose permission forbids the access |
| fill_en | input | 1 | Write a mapping at this edge |
| fill_vpn | input | 8 | Page number of the mapping |
| fill_ppn | input | 6 | Physical page of the mapping |
| fill_rd_ok | input | 1 | Read permission of the mapping |
| fill_wr_ok | input | 1 | Write permission of the mapping |
| flush | input | 1 | Invalidate all entries |

## Verification
A stale or wrong valid bit shows up at the very next lookup of the affected page, as a hit that should be a miss or the reverse. A wrong tag or page field shows up as a wrong `lk_ppn` in the same cycle. A misplaced victim choice stays hidden until the set is full. It then appears as the wrong page going missing after the fifth refill into that set. For that reason the bench fills sets past capacity, and in one case flushes between rounds, so that a pointer error becomes visible a few cycles later as an unexpected miss.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int unsigned XL_VPN_W   = 8;
  parameter int unsigned XL_SET_BITS = 2;
  parameter int unsigned XL_WAYS    = 4;
  parameter int unsigned XL_PPN_W   = 6;
  parameter int unsigned XL_OFS_W   = 6;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } xl_acc_e;
endpackage

// File: rtl/xlat_set_bank.sv
module xlat_set_bank #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned PPN_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        wr_en,
  input  logic [WAYS-1:0]             wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [PPN_W-1:0]            wr_ppn,
  input  logic                        wr_rd_ok,
  input  logic                        wr_wr_ok,
  output logic [WAYS-1:0]             vld,
  output logic [WAYS-1:0][TAG_W-1:0]  tags,
  output logic [WAYS-1:0][PPN_W-1:0]  ppns,
  output logic [WAYS-1:0]             rd_ok,
  output logic [WAYS-1:0]             wr_ok
);
  logic [WAYS-1:0] vld_nxt;

  always_comb begin
    vld_nxt = vld;
    if (flush) begin
      vld_nxt = '0;
    end else if (wr_en) begin
      vld_nxt = vld | wr_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      vld <= vld_nxt;
    end
  end

  // payload fields carry no reset; the valid bit qualifies them
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (wr_en && wr_way[w]) begin
        tags[w]  <= wr_tag;
        ppns[w]  <= wr_ppn;
        rd_ok[w] <= wr_rd_ok;
        wr_ok[w] <= wr_wr_ok;
      end
    end
  end
endmodule

// File: rtl/xlat_tag_match.sv
module xlat_tag_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned PPN_W = 6
) (
  input  logic [TAG_W-1:0]            key,
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [WAYS-1:0][PPN_W-1:0]  ppns,
  input  logic [WAYS-1:0]             rd_ok,
  input  logic [WAYS-1:0]             wr_ok,
  output logic [WAYS-1:0]             way_hit,
  output logic                        any_hit,
  output logic [PPN_W-1:0]            hit_ppn,
  output logic                        hit_rd_ok,
  output logic                        hit_wr_ok
);
  always_comb begin
    hit_ppn   = '0;
    hit_rd_ok = 1'b0;
    hit_wr_ok = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      way_hit[w] = vld[w] && (tags[w] == key);
      hit_ppn    = hit_ppn | ({PPN_W{way_hit[w]}} & ppns[w]);
      hit_rd_ok  = hit_rd_ok | (way_hit[w] & rd_ok[w]);
      hit_wr_ok  = hit_wr_ok | (way_hit[w] & wr_ok[w]);
    end
    any_hit = |way_hit;
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  output logic [WAYS-1:0]             way_sel
);
  localparam int unsigned PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [PTR_W-1:0] rr_q;
  logic [PTR_W-1:0] rr_nxt;
  logic [WAYS-1:0]  dup;
  logic [WAYS-1:0]  free_pick;
  logic [WAYS-1:0]  rr_pick;
  logic             has_dup;
  logic             has_free;
  logic             rr_use;

  always_comb begin
    dup       = '0;
    free_pick = '0;
    rr_pick   = '0;
    for (int w = 0; w < WAYS; w++) begin
      dup[w] = vld[w] && (tags[w] == fill_tag);
      if (rr_q == PTR_W'(w)) rr_pick[w] = 1'b1;
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) begin
        free_pick    = '0;
        free_pick[w] = 1'b1;
      end
    end
    has_dup  = |dup;
    has_free = ~&vld;
    rr_use   = !has_dup && !has_free;
    if (has_dup)       way_sel = dup;
    else if (has_free) way_sel = free_pick;
    else               way_sel = rr_pick;
  end

  always_comb begin
    rr_nxt = rr_q;
    if (go && rr_use) begin
      rr_nxt = (rr_q == PTR_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else begin
      rr_q <= rr_nxt;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W    = XL_VPN_W,
  parameter int unsigned SET_BITS = XL_SET_BITS,
  parameter int unsigned WAYS     = XL_WAYS,
  parameter int unsigned PPN_W    = XL_PPN_W,
  parameter int unsigned OFS_W    = XL_OFS_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFS_W-1:0]       lk_ofs,
  input  logic                   lk_write,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic [PPN_W-1:0]       lk_ppn,
  output logic [PPN_W+OFS_W-1:0] lk_paddr,
  output logic                   lk_fault,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_rd_ok,
  input  logic                   fill_wr_ok,
  input  logic                   flush
);
  localparam int unsigned SETS  = 1 << SET_BITS;
  localparam int unsigned TAG_W = VPN_W - SET_BITS;

  logic [SET_BITS-1:0] lk_set;
  logic [TAG_W-1:0]    lk_tag;
  logic [SET_BITS-1:0] fill_set;
  logic [TAG_W-1:0]    fill_tag;
  logic                fill_go;
  xl_acc_e             acc;

  logic [SETS-1:0][WAYS-1:0]             set_vld;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  set_tag;
  logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  set_ppn;
  logic [SETS-1:0][WAYS-1:0]             set_rd;
  logic [SETS-1:0][WAYS-1:0]             set_wr;
  logic [SETS-1:0][WAYS-1:0]             set_sel;

  logic [WAYS-1:0]  lk_way_hit;
  logic             m_hit;
  logic [PPN_W-1:0] m_ppn;
  logic             m_rd;
  logic             m_wr;

  assign lk_set   = lk_vpn[SET_BITS-1:0];
  assign lk_tag   = lk_vpn[VPN_W-1:SET_BITS];
  assign fill_set = fill_vpn[SET_BITS-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:SET_BITS];
  assign fill_go  = fill_en && !flush;
  assign acc      = lk_write ? ACC_WRITE : ACC_READ;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic set_go;
    assign set_go = fill_go && (fill_set == SET_BITS'(s));

    xlat_victim #(
      .WAYS (WAYS),
      .TAG_W(TAG_W)
    ) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (set_go),
      .fill_tag(fill_tag),
      .vld     (set_vld[s]),
      .tags    (set_tag[s]),
      .way_sel (set_sel[s])
    );

    xlat_set_bank #(
      .WAYS (WAYS),
      .TAG_W(TAG_W),
      .PPN_W(PPN_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (set_go),
      .wr_way  (set_sel[s]),
      .wr_tag  (fill_tag),
      .wr_ppn  (fill_ppn),
      .wr_rd_ok(fill_rd_ok),
      .wr_wr_ok(fill_wr_ok),
      .vld     (set_vld[s]),
      .tags    (set_tag[s]),
      .ppns    (set_ppn[s]),
      .rd_ok   (set_rd[s]),
      .wr_ok   (set_wr[s])
    );
  end

  xlat_tag_match #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .PPN_W(PPN_W)
  ) u_match (
    .key      (lk_tag),
    .vld      (set_vld[lk_set]),
    .tags     (set_tag[lk_set]),
    .ppns     (set_ppn[lk_set]),
    .rd_ok    (set_rd[lk_set]),
    .wr_ok    (set_wr[lk_set]),
    .way_hit  (lk_way_hit),
    .any_hit  (m_hit),
    .hit_ppn  (m_ppn),
    .hit_rd_ok(m_rd),
    .hit_wr_ok(m_wr)
  );

  always_comb begin
    lk_hit   = lk_valid && m_hit;
    lk_miss  = lk_valid && !m_hit;
    lk_ppn   = lk_hit ? m_ppn : '0;
    lk_paddr = lk_hit ? {m_ppn, lk_ofs} : '0;
    unique case (acc)
      ACC_WRITE: lk_fault = lk_hit && !m_wr;
      default:   lk_fault = lk_hit && !m_rd;
    endcase
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned VPN_W = 8,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned PPN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic [PPN_W-1:0] lk_ppn,
  input logic             lk_fault,
  input logic             fill_en,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PPN_W-1:0] fill_ppn,
  input logic             flush,
  input logic [WAYS-1:0]  way_hit
);
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !lk_hit);

  assert_hit_miss_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  assert_fill_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=>
      (!(lk_valid && lk_vpn == $past(fill_vpn)) || (lk_hit && lk_ppn == $past(fill_ppn))));

  assert_single_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  assert_fault_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);
endmodule

bind xlat_cache xlat_cache_chk #(
  .VPN_W(VPN_W),
  .WAYS (WAYS),
  .PPN_W(PPN_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lk_valid(lk_valid),
  .lk_vpn  (lk_vpn),
  .lk_hit  (lk_hit),
  .lk_miss (lk_miss),
  .lk_ppn  (lk_ppn),
  .lk_fault(lk_fault),
  .fill_en (fill_en),
  .fill_vpn(fill_vpn),
  .fill_ppn(fill_ppn),
  .flush   (flush),
  .way_hit (lk_way_hit)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [7:0]  lk_vpn;
  logic [5:0]  lk_ofs;
  logic        lk_write;
  logic        lk_hit;
  logic        lk_miss;
  logic [5:0]  lk_ppn;
  logic [11:0] lk_paddr;
  logic        lk_fault;
  logic        fill_en;
  logic [7:0]  fill_vpn;
  logic [5:0]  fill_ppn;
  logic        fill_rd_ok;
  logic        fill_wr_ok;
  logic        flush;

  int checks = 0;
  int errors = 0;

  xlat_cache i_xlat_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ofs(lk_ofs), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_paddr(lk_paddr),
    .lk_fault(lk_fault),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rd_ok(fill_rd_ok), .fill_wr_ok(fill_wr_ok), .flush(flush)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // inputs change at the falling edge; outputs are read 2 ns later
  task automatic look(input logic [7:0] vpn, input logic [5:0] ofs, input logic wr);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = vpn; lk_ofs = ofs; lk_write = wr;
    #2;
  endtask

  task automatic expect_hit(input string req, input logic [7:0] vpn, input logic [5:0] ppn);
    look(vpn, 6'h00, 1'b0);
    chk({req, " hit"}, lk_hit, 1'b1);
    chk({req, " ppn"}, lk_ppn, ppn);
  endtask

  task automatic expect_miss(input string req, input logic [7:0] vpn);
    look(vpn, 6'h00, 1'b0);
    chk({req, " miss"}, lk_miss, 1'b1);
    chk({req, " nohit"}, lk_hit, 1'b0);
  endtask

  task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn, input logic rd, input logic wr);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rd_ok = rd; fill_wr_ok = wr;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    expect_miss("R1 vpn 00", 8'h00);
    expect_miss("R1 vpn A7", 8'hA7);
    @(negedge clk);
    lk_valid = 1'b0; lk_vpn = 8'h00; #2;
    chk("R4 idle hit", lk_hit, 1'b0);
    chk("R4 idle miss", lk_miss, 1'b0);
  endtask

  task automatic t_basic();
    // fill 0x35 (set 1, tag 0x0D); same cycle lookup still misses (R5)
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 8'h35; fill_ppn = 6'h2A; fill_rd_ok = 1'b1; fill_wr_ok = 1'b1;
    lk_valid = 1'b1; lk_vpn = 8'h35; lk_ofs = 6'h17; lk_write = 1'b0;
    #2;
    chk("R5 before edge", lk_hit, 1'b0);
    @(posedge clk); #2;
    chk("R5 after edge", lk_hit, 1'b1);
    chk("R3 ppn", lk_ppn, 6'h2A);
    chk("R3 paddr", lk_paddr, 12'hA97);
    @(negedge clk); fill_en = 1'b0;
    expect_miss("R2 other tag same set", 8'h39);
    expect_miss("R2 same tag other set", 8'h34);
    chk("R3 paddr on miss", lk_paddr, 12'h000);
    chk("R3 ppn on miss", lk_ppn, 6'h00);
  endtask

  task automatic t_perm();
    fill(8'h80, 6'h05, 1'b1, 1'b0);
    look(8'h80, 6'h3F, 1'b0);
    chk("R10 read ok hit", lk_hit, 1'b1);
    chk("R10 read ok nofault", lk_fault, 1'b0);
    look(8'h80, 6'h3F, 1'b1);
    chk("R10 write fault", lk_fault, 1'b1);
    chk("R10 write still hit", lk_hit, 1'b1);
    chk("R10 write ppn", lk_ppn, 6'h05);
    fill(8'hC1, 6'h09, 1'b0, 1'b1);
    look(8'hC1, 6'h00, 1'b0);
    chk("R10 read forbidden", lk_fault, 1'b1);
    look(8'hC5, 6'h00, 1'b1);
    chk("R10 miss no fault", lk_fault, 1'b0);
  endtask

  task automatic t_replace();
    do_flush();
    // set 2: four pages fill ways 0..3 in order
    for (int i = 1; i <= 4; i++) fill(8'((i << 2) | 2), 6'(8'h10 + i), 1'b1, 1'b1);
    for (int i = 1; i <= 4; i++) expect_hit("R6 set full", 8'((i << 2) | 2), 6'(8'h10 + i));
    fill(8'h16, 6'h15, 1'b1, 1'b1);      // pointer 0 -> evict 0x06
    expect_miss("R7 first victim", 8'h06);
    expect_hit("R7 new page", 8'h16, 6'h15);
    expect_hit("R7 way1 kept", 8'h0A, 6'h12);
    fill(8'h1A, 6'h16, 1'b1, 1'b1);      // pointer 1 -> evict 0x0A
    expect_miss("R7 second victim", 8'h0A);
    expect_hit("R7 way2 kept", 8'h0E, 6'h13);
    // flush keeps pointer at 2; refill four pages through free ways, fifth evicts third
    do_flush();
    expect_miss("R9 flushed", 8'h16);
    fill(8'h22, 6'h21, 1'b1, 1'b1);
    fill(8'h26, 6'h22, 1'b1, 1'b1);
    fill(8'h2A, 6'h23, 1'b1, 1'b1);
    fill(8'h2E, 6'h24, 1'b1, 1'b1);
    fill(8'h32, 6'h25, 1'b1, 1'b1);
    expect_miss("R6 R7 pointer kept over flush", 8'h2A);
    expect_hit("R6 way0", 8'h22, 6'h21);
    expect_hit("R6 way1", 8'h26, 6'h22);
    expect_hit("R6 way3", 8'h2E, 6'h24);
    expect_hit("R7 replaced", 8'h32, 6'h25);
  endtask

  task automatic t_dup();
    do_flush();
    for (int i = 1; i <= 4; i++) fill(8'(i << 2), 6'(i), 1'b1, 1'b1);
    fill(8'h08, 6'h3F, 1'b1, 1'b1);      // already cached: overwrite in place
    expect_hit("R8 overwrite", 8'h08, 6'h3F);
    expect_hit("R8 others kept", 8'h04, 6'h01);
    expect_hit("R8 others kept", 8'h10, 6'h04);
    fill(8'h14, 6'h05, 1'b1, 1'b1);      // pointer still 0 -> evict 0x04
    expect_miss("R8 pointer unmoved", 8'h04);
    expect_hit("R8 dup survives", 8'h08, 6'h3F);
  endtask

  task automatic t_flush();
    fill(8'h44, 6'h11, 1'b1, 1'b1);
    expect_hit("R9 pre", 8'h44, 6'h11);
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 8'h48; fill_ppn = 6'h12;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    expect_miss("R9 cleared", 8'h44);
    expect_miss("R9 fill dropped", 8'h48);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vpn = '0; lk_ofs = '0; lk_write = 1'b0;
    fill_en = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_rd_ok = 1'b0; fill_wr_ok = 1'b0;
    flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_perm();
    t_replace();
    t_dup();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule